// File: doc/BRIEF.md
# Host Buffer Command Loader

This block moves a buffer of 32-bit words from host memory into the command queue of a graphics pipeline. The buffer holds register tags and data words, in the same form that the host would otherwise write one at a time. The block does not interpret these words. It delivers them in their original order.

Software first writes the buffer start address to the base register. It then writes the number of words to the count register, and that write starts the transfer. The engine sends one read request at a time over a simple valid/ready memory read port. It waits for each response and pushes the returned word into the queue. It then steps the address by 4 bytes and lowers the count.

A request is issued only while the queue reports at least one free slot. The queue therefore never overflows, and the host never has to poll for room. The remaining count can be read back at any time. A one-cycle done pulse marks the end of the transfer.

Top module: `hdma_loader`

## Requirements
- R1: After reset the engine is idle (`busy` low), `cnt_left` is 0, and `mem_req_valid`, `q_push` and `done` are all low.
- R2: A write with `reg_wr_sel`=1 (count) and a nonzero count, while the engine is idle, starts a transfer. In the cycle after the write, `busy` is high and `mem_addr` equals the base register value.
- R3: `mem_req_valid` is raised only while `q_free` is nonzero. No word is pushed while `q_free` is 0, and a full queue halts the transfer until space returns.
- R4: The request address starts at the base and grows by exactly 4 for each word transferred.
- R5: `cnt_left` reads back the number of words still to transfer. It drops by one on each push and is 0 at the end.
- R6: Each word returned on `mem_rsp_data` is pushed to `q_data` unchanged, in request order, in the cycle that `mem_rsp_valid` is high.
- R7: At most one read is outstanding. After a request is accepted, no new request is made until its response has been pushed. An unaccepted request keeps its address stable.
- R8: Writing a count of 0 starts nothing: `busy` stays low and no request is made.
- R9: While a transfer is active, writes to the count register are ignored, and a base write does not move the running address. A base written during a transfer is used by the next transfer.
- R10: `done` is high for exactly one cycle, the cycle after the final push. `busy` is low in that same cycle.
- R11: Only the low 16 bits of a count write are used, so the largest transfer is 65535 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 0 selects the base register, 1 selects the count register |
| reg_wr_data | input | 32 | Register write data |
| cnt_left | output | 16 | Words still to transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_addr | output | 32 | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| q_free | input | 9 | Free slots in the command queue |
| q_push | output | 1 | Push a word into the queue |
| q_data | output | 32 | Word pushed into the queue |

## Verification
The bench drains the queue at controlled rates. It also holds the queue at zero free slots in the middle of a transfer; a design that checked for room only at start, or checked it after issuing the read, would push into a full queue, and the queue model flags that push. Reads are given several cycles of latency with a toggling ready, so a design that pipelined a second request or let the address drift while a request was stalled would produce a duplicate or skipped address. The bench writes both registers during an active transfer, and writes counts of zero and counts with high bits set. A design that restarted on such writes, or used the new base too early, would return the wrong word sequence or the wrong length. It also checks that `done` fires once, in the cycle after the last push.

// File: rtl/hdma_pkg.sv
package hdma_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int CNT_W      = 16;
  localparam int WORD_BYTES = 4;

  localparam logic SEL_BASE  = 1'b0;
  localparam logic SEL_COUNT = 1'b1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_t;

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(WORD_BYTES);
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  function automatic logic cnt_is_last(input logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction
endpackage

// File: rtl/hdma_regs.sv
module hdma_regs
  import hdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic              step,
  output logic [ADDR_W-1:0] base_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              start
);
  logic count_wr;
  logic [CNT_W-1:0] wr_count;

  assign wr_count = wr_data[CNT_W-1:0];
  assign count_wr = wr_en && (wr_sel == SEL_COUNT);
  assign start    = count_wr && !busy && (wr_count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_en && (wr_sel == SEL_BASE))
        base_q <= wr_data[ADDR_W-1:0];
      if (start)
        cnt_q <= wr_count;
      else if (step)
        cnt_q <= cnt_step(cnt_q);
    end
  end

  // R5: each step lowers the count by one
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R9: while active, the count only moves on a step
  a_r9_busy_ignores_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step) |=> $stable(cnt_q));
endmodule

// File: rtl/hdma_seq.sv
module hdma_seq
  import hdma_pkg::*;
#(
  parameter int FREE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [FREE_W-1:0] q_free,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              step,
  output logic              q_push,
  output logic [DATA_W-1:0] q_data,
  output logic              done
);
  seq_state_t state_q;
  logic [ADDR_W-1:0] addr_q;
  logic has_room;
  logic req_fire;
  logic last_word;

  assign has_room  = (q_free != '0);
  assign busy      = (state_q != ST_IDLE);
  assign req_valid = (state_q == ST_ISSUE) && has_room;
  assign req_fire  = req_valid && req_ready;
  assign step      = (state_q == ST_WAIT) && rsp_valid;
  assign last_word = step && cnt_is_last(cnt_q);
  assign q_push    = step;
  assign q_data    = rsp_data;
  assign req_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= last_word;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            addr_q  <= base_q;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (req_fire) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (step) begin
            addr_q  <= addr_step(addr_q);
            state_q <= last_word ? ST_IDLE : ST_ISSUE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: never push into a full queue
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |-> q_free != '0);

  // R4: address advances one word per push
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |=> req_addr == $past(req_addr) + ADDR_W'(WORD_BYTES));

  // R7: a stalled request holds its address, and is not withdrawn while room remains
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  // R7: no second request before the response
  a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_valid);
endmodule

// File: rtl/hdma_loader.sv
module hdma_loader
  import hdma_pkg::*;
#(
  parameter int FREE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_wr_sel,
  input  logic [31:0]       reg_wr_data,
  output logic [15:0]       cnt_left,
  output logic              busy,
  output logic              done,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  input  logic [FREE_W-1:0] q_free,
  output logic              q_push,
  output logic [31:0]       q_data
);
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic start;
  logic step;

  hdma_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_sel  (reg_wr_sel),
    .wr_data (reg_wr_data),
    .busy    (busy),
    .step    (step),
    .base_q  (base_q),
    .cnt_q   (cnt_q),
    .start   (start)
  );

  hdma_seq #(.FREE_W(FREE_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .base_q    (base_q),
    .cnt_q     (cnt_q),
    .q_free    (q_free),
    .req_ready (mem_req_ready),
    .rsp_valid (mem_rsp_valid),
    .rsp_data  (mem_rsp_data),
    .busy      (busy),
    .req_valid (mem_req_valid),
    .req_addr  (mem_addr),
    .step      (step),
    .q_push    (q_push),
    .q_data    (q_data),
    .done      (done)
  );

  assign cnt_left = cnt_q;

  // R10: done is a single-cycle pulse with the engine idle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cnt_left == '0));

  // R8: a zero count written while idle starts nothing
  a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_sel && reg_wr_data[15:0] == 16'd0 && !busy) |=> !busy);
endmodule

// File: tb/sim_hdma_loader.sv
`timescale 1ns/1ps
module sim_hdma_loader;
  localparam int FREE_W = 9;
  localparam int DEPTH  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic reg_wr_sel = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [15:0] cnt_left;
  logic busy, done, mem_req_valid, q_push;
  logic mem_req_ready = 1'b1;
  logic [31:0] mem_addr, q_data;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [FREE_W-1:0] q_free;

  int tests = 0;
  int fails = 0;

  int cap = DEPTH;
  logic drain = 1'b1;
  int lat_cfg = 0;
  logic rdy_toggle = 1'b0;

  always #2 clk = ~clk;

  hdma_loader #(.FREE_W(FREE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .cnt_left(cnt_left), .busy(busy), .done(done),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .q_free(q_free),
    .q_push(q_push), .q_data(q_data)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'd3) ^ 32'hC0DE_0000;
  endfunction

  // memory model
  logic pend = 1'b0;
  logic [31:0] pend_addr = '0;
  int lat_left = 0;
  int outstanding_err = 0;
  logic [31:0] req_log [0:1023];
  int n_req = 0;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    mem_req_ready <= rdy_toggle ? ~mem_req_ready : 1'b1;
    if (!rst_n) begin
      pend <= 1'b0;
    end else begin
      if (pend) begin
        if (lat_left == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= pat(pend_addr);
          pend <= 1'b0;
        end else begin
          lat_left <= lat_left - 1;
        end
      end
      if (mem_req_valid && mem_req_ready) begin
        if (pend || mem_rsp_valid) outstanding_err <= outstanding_err + 1;
        pend <= 1'b1;
        pend_addr <= mem_addr;
        lat_left <= lat_cfg;
        req_log[n_req % 1024] <= mem_addr;
        n_req <= n_req + 1;
      end
    end
  end

  // queue model
  int occ = 0;
  int ovf_err = 0;
  logic [31:0] got [0:1023];
  int n_got = 0;
  int done_cnt = 0;
  int done_wide = 0;
  logic done_prev = 1'b0;

  assign q_free = (cap > occ) ? FREE_W'(cap - occ) : '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      occ <= 0;
      done_prev <= 1'b0;
    end else begin
      occ <= occ + (q_push ? 1 : 0) - ((drain && occ > 0) ? 1 : 0);
      if (q_push) begin
        if (occ >= cap) ovf_err <= ovf_err + 1;
        got[n_got % 1024] <= q_data;
        n_got <= n_got + 1;
      end
      done_prev <= done;
      if (done) done_cnt <= done_cnt + 1;
      if (done && done_prev) done_wide <= done_wide + 1;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    int n = 0;
    while (done_cnt == d0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(done_cnt != d0, "R10 timeout", n, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic verify(input int s_req, input int s_got, input logic [31:0] base, input int words, input string tag);
    int bad_a = 0, bad_d = 0;
    check(n_got - s_got == words, {tag, " R5 word total"}, n_got - s_got, words);
    for (int i = 0; i < words; i++) begin
      if (req_log[(s_req + i) % 1024] != base + 32'(4 * i)) bad_a++;
      if (got[(s_got + i) % 1024] != pat(base + 32'(4 * i))) bad_d++;
    end
    check(bad_a == 0, {tag, " R4 address sequence"}, bad_a, 0);
    check(bad_d == 0, {tag, " R6 data order"}, bad_d, 0);
    check(cnt_left == 0 && !busy, {tag, " R5 final count"}, cnt_left, 0);
  endtask

  task automatic run_xfer(input logic [31:0] base, input logic [31:0] cnt_wr, input int words,
                          input int lat, input logic tog, input string tag);
    int s_req, s_got, d0;
    lat_cfg = lat; rdy_toggle = tog;
    wr(1'b0, base);
    s_req = n_req; s_got = n_got; d0 = done_cnt;
    wr(1'b1, cnt_wr);
    check(busy && mem_addr == base, {tag, " R2 start"}, mem_addr, base);
    wait_done(d0);
    verify(s_req, s_got, base, words, tag);
    check(done_cnt - d0 == 1 && done_wide == 0, {tag, " R10 done once"}, done_cnt - d0, 1);
    check(outstanding_err == 0, {tag, " R7 one outstanding"}, outstanding_err, 0);
    check(ovf_err == 0, {tag, " R3 no overflow"}, ovf_err, 0);
  endtask

  task automatic t_reset();
    check(!busy && cnt_left == 0 && !mem_req_valid && !q_push && !done, "R1 reset state",
          {busy, mem_req_valid, q_push, done}, 0);
  endtask

  task automatic t_backpressure();
    int s_req, s_got, d0;
    lat_cfg = 0; rdy_toggle = 1'b0;
    cap = 2; drain = 1'b0;
    repeat (4) @(negedge clk);
    wr(1'b0, 32'h0000_4000);
    s_req = n_req; s_got = n_got; d0 = done_cnt;
    wr(1'b1, 32'd6);
    repeat (40) @(negedge clk);
    check(n_got - s_got == 2, "R3 halted at full", n_got - s_got, 2);
    check(cnt_left == 4, "R5 count while halted", cnt_left, 4);
    check(busy && !mem_req_valid, "R3 no request when full", mem_req_valid, 0);
    drain = 1'b1;
    wait_done(d0);
    verify(s_req, s_got, 32'h0000_4000, 6, "bp");
    check(ovf_err == 0, "R3 no overflow", ovf_err, 0);
    cap = DEPTH;
  endtask

  task automatic t_zero();
    int g0 = n_got, r0 = n_req;
    wr(1'b1, 32'd0);
    check(!busy && !mem_req_valid, "R8 zero count no start", busy, 0);
    repeat (5) @(negedge clk);
    check(n_got == g0 && n_req == r0 && cnt_left == 0, "R8 nothing moved", n_req - r0, 0);
  endtask

  task automatic t_busy_write();
    int s_req, s_got, d0;
    logic [15:0] c0;
    lat_cfg = 5; rdy_toggle = 1'b0;
    wr(1'b0, 32'h0002_0000);
    s_req = n_req; s_got = n_got; d0 = done_cnt;
    wr(1'b1, 32'd8);
    repeat (10) @(negedge clk);
    c0 = cnt_left;
    wr(1'b1, 32'd3);
    check(cnt_left <= c0 && cnt_left + 1 >= c0, "R9 count write ignored", cnt_left, c0);
    wr(1'b0, 32'h0003_0000);
    wait_done(d0);
    verify(s_req, s_got, 32'h0002_0000, 8, "busy");
    s_req = n_req; s_got = n_got; d0 = done_cnt;
    lat_cfg = 0;
    wr(1'b1, 32'd2);
    check(mem_addr == 32'h0003_0000, "R9 new base used next", mem_addr, 32'h0003_0000);
    wait_done(d0);
    verify(s_req, s_got, 32'h0003_0000, 2, "next");
  endtask

  initial begin
    #(4 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_xfer(32'h0000_1000, 32'd5, 5, 0, 1'b0, "basic");
    run_xfer(32'h8000_0FF0, 32'd7, 7, 3, 1'b1, "slow");
    run_xfer(32'h0000_0200, 32'd1, 1, 1, 1'b0, "single");
    t_backpressure();
    t_zero();
    t_busy_write();
    run_xfer(32'h0010_0000, 32'hABCD_0003, 3, 0, 1'b1, "R11 high bits");
    run_xfer(32'h0000_5000, 32'd300, 300, 0, 1'b0, "long");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule